// File: doc/BRIEF.md
# Video Frame Write-Burst Controller

This block moves decoded video from a buffering FIFO into SDRAM in fixed bursts of eight 32-bit words. It watches the fill count that the FIFO reports in the memory clock domain. Once a whole burst is waiting, it raises a write request toward the memory arbiter. After the grant arrives, it releases one FIFO word for each data-accept strobe from the memory controller until eight words have gone out.

Alongside each request the block presents the burst's SDRAM address. The address is built from three counters: a burst column within the active line, the active line within the field, and the field parity. The counters visit every active line of both interlaced fields (254 lines in the odd field, 253 in the even one, 45 bursts per line), then wrap back to the start of the frame. Blanking lines are never addressed.

Top module: `frame_burst_writer`

## Requirements
- R1: `wr_req` rises only in the cycle after an idle cycle in which `fifo_level` was at least 8. While `fifo_level` stays below 8 in idle, `wr_req` stays low.
- R2: Once raised, `wr_req` stays high until a cycle with `wr_grant` high. It is low in the following cycle.
- R3: After a grant, `fifo_pop` is high in exactly the cycles in which `wr_data_take` is high, for 8 such cycles, and is combinational with `wr_data_take`. A `wr_data_take` outside a granted burst produces no pop, raises no request and leaves the address unchanged.
- R4: `row_addr` (13 bits) equals {4'b0000, line[7:0], field}, with the field bit in bit 0 (0 = odd field, 1 = even field). `bank_addr` is always 0.
- R5: `col_addr` (9 bits) equals {burst[5:0], 3'b000}, with burst running 0 to 44. After burst 44 the burst resets to 0 and the line advances.
- R6: The line runs 0 to 253 in field 0 and 0 to 252 in field 1. After the last line of a field the line resets to 0 and the field bit toggles, so field 1 is followed by field 0, line 0, burst 0.
- R7: During reset and right after it, `wr_req` and `fifo_pop` are low and the address is line 0, field 0, burst 0 (row 0, column 0).
- R8: The address holds steady from the request until the 8th accepted word. It shows the next burst's address in the cycle after that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_level | input | 10 | Words currently held in the input FIFO (memory domain) |
| wr_grant | input | 1 | Arbiter grant for the pending write request |
| wr_data_take | input | 1 | Controller strobe: the current write word is accepted this cycle |
| wr_req | output | 1 | Write burst request to the arbiter |
| fifo_pop | output | 1 | Advance the FIFO read side by one word |
| row_addr | output | 13 | SDRAM row of the current burst |
| bank_addr | output | 2 | SDRAM bank of the current burst |
| col_addr | output | 9 | SDRAM start column of the current burst |

## Verification
The hardest cycle is the 8th accepted word of a burst when it is also the last burst of a line, the last line of a field, or the last line of the frame. In that single edge the beat counter clears, the state returns to idle and up to three address counters carry together. The bench forces these coincidences by running every burst of the whole odd field on the full-size instance, and a full frame twice on a small-parameter instance. It varies grant delay, take gaps and stray strobes at random. In the cycle after each final word, the bench compares the new row and column against its own counter model, and checks that the pop has already stopped and that no request came up early.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } fbw_state_e;

endpackage

// File: rtl/fbw_addr_gen.sv
module fbw_addr_gen #(
  parameter int LINE_W          = 8,
  parameter int BCOL_W          = 6,
  parameter int ODD_LINES       = 254,
  parameter int EVEN_LINES      = 253,
  parameter int BURSTS_PER_LINE = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [BCOL_W-1:0] bcol,
  output logic [LINE_W-1:0] line,
  output logic              field
);

  localparam logic [BCOL_W-1:0] BCOL_LAST = BCOL_W'(BURSTS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] ODD_LAST  = LINE_W'(ODD_LINES - 1);
  localparam logic [LINE_W-1:0] EVEN_LAST = LINE_W'(EVEN_LINES - 1);

  logic [BCOL_W-1:0] bcol_q, bcol_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              field_q, field_d;
  logic [LINE_W-1:0] line_last;
  logic              col_wrap;
  logic              line_wrap;

  // field 0 carries the longer (odd) field
  assign line_last = field_q ? EVEN_LAST : ODD_LAST;
  assign col_wrap  = (bcol_q == BCOL_LAST);
  assign line_wrap = (line_q == line_last);

  always_comb begin
    bcol_d  = bcol_q;
    line_d  = line_q;
    field_d = field_q;
    if (col_wrap) begin
      bcol_d = '0;
      if (line_wrap) begin
        line_d  = '0;
        field_d = ~field_q;
      end else begin
        line_d = line_q + 1'b1;
      end
    end else begin
      bcol_d = bcol_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcol_q  <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
    end else if (adv) begin
      bcol_q  <= bcol_d;
      line_q  <= line_d;
      field_q <= field_d;
    end
  end

  assign bcol  = bcol_q;
  assign line  = line_q;
  assign field = field_q;

endmodule

// File: rtl/fbw_burst_fsm.sv
module fbw_burst_fsm
  import fbw_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int LVL_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             wr_grant,
  input  logic             wr_data_take,
  output logic             wr_req,
  output logic             fifo_pop,
  output logic             burst_done
);

  localparam int               BEAT_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);
  localparam logic [LVL_W-1:0]  LVL_MIN   = LVL_W'(BURST_LEN);

  fbw_state_e        st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              lvl_ok;
  logic              in_xfer;

  assign lvl_ok     = (fifo_level >= LVL_MIN);
  assign in_xfer    = (st_q == ST_XFER);
  assign fifo_pop   = in_xfer & wr_data_take;
  assign burst_done = fifo_pop & (beat_q == BEAT_LAST);
  assign wr_req     = (st_q == ST_REQ);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (lvl_ok)     st_d = ST_REQ;
      ST_REQ:  if (wr_grant)   st_d = ST_XFER;
      ST_XFER: if (burst_done) st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    beat_d = beat_q;
    if (fifo_pop) beat_d = burst_done ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_q <= '0;
    else if (fifo_pop) beat_q <= beat_d;
  end

endmodule

// File: rtl/fbw_addr_pack.sv
module fbw_addr_pack #(
  parameter int LINE_W    = 8,
  parameter int BCOL_W    = 6,
  parameter int ROW_PAD   = 4,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 8
) (
  input  logic [BCOL_W-1:0]                     bcol,
  input  logic [LINE_W-1:0]                     line,
  input  logic                                  field,
  output logic [ROW_PAD+LINE_W:0]               row_addr,
  output logic [BANK_W-1:0]                     bank_addr,
  output logic [BCOL_W+$clog2(BURST_LEN)-1:0]   col_addr
);

  localparam int BSHIFT = $clog2(BURST_LEN);

  generate
    if (ROW_PAD > 0) begin : g_row_pad
      assign row_addr = {{ROW_PAD{1'b0}}, line, field};
    end else begin : g_row_nopad
      assign row_addr = {line, field};
    end
    if (BSHIFT > 0) begin : g_col_shift
      assign col_addr = {bcol, {BSHIFT{1'b0}}};
    end else begin : g_col_flat
      assign col_addr = bcol;
    end
  endgenerate

  assign bank_addr = '0;

endmodule

// File: rtl/frame_burst_writer.sv
module frame_burst_writer #(
  parameter int LVL_W           = 10,
  parameter int BURST_LEN       = 8,
  parameter int LINE_W          = 8,
  parameter int BCOL_W          = 6,
  parameter int ROW_PAD         = 4,
  parameter int BANK_W          = 2,
  parameter int ODD_LINES       = 254,
  parameter int EVEN_LINES      = 253,
  parameter int BURSTS_PER_LINE = 45
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [LVL_W-1:0]                    fifo_level,
  input  logic                                wr_grant,
  input  logic                                wr_data_take,
  output logic                                wr_req,
  output logic                                fifo_pop,
  output logic [ROW_PAD+LINE_W:0]             row_addr,
  output logic [BANK_W-1:0]                   bank_addr,
  output logic [BCOL_W+$clog2(BURST_LEN)-1:0] col_addr
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              burst_done;
  logic [BCOL_W-1:0] bcol;
  logic [LINE_W-1:0] line;
  logic              field;

  // asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fbw_burst_fsm #(
    .BURST_LEN (BURST_LEN),
    .LVL_W     (LVL_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .fifo_level   (fifo_level),
    .wr_grant     (wr_grant),
    .wr_data_take (wr_data_take),
    .wr_req       (wr_req),
    .fifo_pop     (fifo_pop),
    .burst_done   (burst_done)
  );

  fbw_addr_gen #(
    .LINE_W          (LINE_W),
    .BCOL_W          (BCOL_W),
    .ODD_LINES       (ODD_LINES),
    .EVEN_LINES      (EVEN_LINES),
    .BURSTS_PER_LINE (BURSTS_PER_LINE)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .adv   (burst_done),
    .bcol  (bcol),
    .line  (line),
    .field (field)
  );

  fbw_addr_pack #(
    .LINE_W    (LINE_W),
    .BCOL_W    (BCOL_W),
    .ROW_PAD   (ROW_PAD),
    .BANK_W    (BANK_W),
    .BURST_LEN (BURST_LEN)
  ) u_pack (
    .bcol      (bcol),
    .line      (line),
    .field     (field),
    .row_addr  (row_addr),
    .bank_addr (bank_addr),
    .col_addr  (col_addr)
  );

endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
  parameter int LVL_W     = 10,
  parameter int BURST_LEN = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fifo_level,
  input logic             wr_grant,
  input logic             wr_data_take,
  input logic             wr_req,
  input logic             fifo_pop,
  input logic [ROW_W-1:0] row_addr,
  input logic [COL_W-1:0] col_addr
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);
  logic [CNT_W-1:0] pops_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pops_q <= '0;
    else if (wr_req)   pops_q <= '0;
    else if (fifo_pop) pops_q <= pops_q + 1'b1;
  end

  AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> ($past(fifo_level) >= LVL_W'(BURST_LEN))); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_grant) |=> wr_req); // R2
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_grant) |=> !wr_req); // R2
  AST_POP_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (wr_data_take && !wr_req)); // R3
  AST_NO_OVERPOP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (pops_q < CNT_W'(BURST_LEN))); // R3
  AST_FULL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> (pops_q == '0 || pops_q == CNT_W'(BURST_LEN))); // R3
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(col_addr) |-> (col_addr == '0 ||
                            col_addr == $past(col_addr) + COL_W'(BURST_LEN))); // R5
  AST_ROW_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (col_addr == '0)); // R6
  AST_ADDR_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> ($stable(row_addr) && $stable(col_addr))); // R8
  AST_ADDR_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(col_addr) |-> $past(fifo_pop)); // R8

endmodule

bind frame_burst_writer fbw_checker #(
  .LVL_W     (LVL_W),
  .BURST_LEN (BURST_LEN),
  .ROW_W     (ROW_PAD + LINE_W + 1),
  .COL_W     (BCOL_W + $clog2(BURST_LEN))
) u_fbw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_level   (fifo_level),
  .wr_grant     (wr_grant),
  .wr_data_take (wr_data_take),
  .wr_req       (wr_req),
  .fifo_pop     (fifo_pop),
  .row_addr     (row_addr),
  .col_addr     (col_addr)
);

// File: tb/frame_burst_writer_tb.sv
`timescale 1ns/1ps
module frame_burst_writer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [9:0]  lvl0, lvl1;
  logic        gnt0, gnt1, tk0, tk1;
  logic        req0, req1, pop0, pop1;
  logic [12:0] row0, row1;
  logic [1:0]  bank0, bank1;
  logic [8:0]  col0, col1;

  frame_burst_writer u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_level(lvl0), .wr_grant(gnt0),
    .wr_data_take(tk0), .wr_req(req0), .fifo_pop(pop0),
    .row_addr(row0), .bank_addr(bank0), .col_addr(col0));

  frame_burst_writer #(.ODD_LINES(3), .EVEN_LINES(2), .BURSTS_PER_LINE(4)) u_small (
    .clk(clk), .rst_n(rst_n), .fifo_level(lvl1), .wr_grant(gnt1),
    .wr_data_take(tk1), .wr_req(req1), .fifo_pop(pop1),
    .row_addr(row1), .bank_addr(bank1), .col_addr(col1));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int e_line[2], e_field[2], e_col[2];
  int odd_n[2]  = '{254, 3};
  int even_n[2] = '{253, 2};
  int bpl[2]    = '{45, 4};

  function automatic logic o_req(int s); return s ? req1 : req0; endfunction
  function automatic logic o_pop(int s); return s ? pop1 : pop0; endfunction
  function automatic logic [12:0] o_row(int s); return s ? row1 : row0; endfunction
  function automatic logic [8:0] o_col(int s); return s ? col1 : col0; endfunction
  function automatic logic [1:0] o_bank(int s); return s ? bank1 : bank0; endfunction

  function automatic logic [12:0] exp_row(int s);
    return {4'b0000, 8'(e_line[s]), e_field[s][0]};
  endfunction
  function automatic logic [8:0] exp_col(int s);
    return {6'(e_col[s]), 3'b000};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drive(int s, logic [9:0] lv, logic g, logic t);
    if (s == 0) begin lvl0 = lv; gnt0 = g; tk0 = t; end
    else        begin lvl1 = lv; gnt1 = g; tk1 = t; end
  endtask

  // model of the address counters
  task automatic model_adv(int s, output bit wrapped);
    int last;
    wrapped = 0;
    if (e_col[s] == bpl[s] - 1) begin
      e_col[s] = 0;
      wrapped = 1;
      last = e_field[s] ? even_n[s] - 1 : odd_n[s] - 1;
      if (e_line[s] == last) begin e_line[s] = 0; e_field[s] ^= 1; end
      else e_line[s]++;
    end else e_col[s]++;
  endtask

  task automatic chk_addr(int s, string rq);
    chk({rq, " row"}, 32'(o_row(s)), 32'(exp_row(s)));
    chk({rq, " col"}, 32'(o_col(s)), 32'(exp_col(s)));
  endtask

  // one burst; called at a negedge in idle state
  task automatic run_burst(int s, int gdly, int gapmax, bit stray);
    bit wr;
    drive(s, 10'(8 + $urandom_range(0, 300)), 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 req up", 32'(o_req(s)), 1);
    chk_addr(s, "R4/R5");
    chk("R4 bank", 32'(o_bank(s)), 0);
    for (int i = 0; i < gdly; i++) begin
      drive(s, 10'd20, 1'b0, stray);
      #1 chk("R3 stray take in request", 32'(o_pop(s)), 0);
      @(negedge clk);
      chk("R2 req held", 32'(o_req(s)), 1);
      chk_addr(s, "R8 hold");
    end
    drive(s, 10'd20, 1'b1, 1'b0);
    @(negedge clk);
    drive(s, 10'd20, 1'b0, 1'b0);
    chk("R2 req drop", 32'(o_req(s)), 0);
    for (int b = 0; b < 8; b++) begin
      int gaps = (gapmax > 0) ? $urandom_range(0, gapmax) : 0;
      for (int g = 0; g < gaps; g++) begin
        drive(s, 10'd20, 1'b0, 1'b0);
        #1 chk("R3 no take no pop", 32'(o_pop(s)), 0);
        @(negedge clk);
      end
      drive(s, 10'd20, 1'b0, 1'b1);
      #1 chk("R3 pop on take", 32'(o_pop(s)), 1);
      @(negedge clk);
      if (b < 7) chk_addr(s, "R8 hold in burst");
    end
    drive(s, 10'd0, 1'b0, 1'b0);
    model_adv(s, wr);
    chk_addr(s, wr ? "R6 line step" : "R8 next addr");
    chk("R3 pop stops", 32'(o_pop(s)), 0);
    chk("R1 no early req", 32'(o_req(s)), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0397));
    for (int s = 0; s < 2; s++) begin
      e_line[s] = 0; e_field[s] = 0; e_col[s] = 0;
      drive(s, 10'd0, 1'b0, 1'b0);
    end
    repeat (3) @(negedge clk);
    chk("R7 req in reset", 32'(req0), 0);
    chk("R7 row in reset", 32'(row0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk("R7 req", 32'(o_req(s)), 0);
      chk("R7 pop", 32'(o_pop(s)), 0);
      chk_addr(s, "R7");
    end

    // R1: seven words are not enough
    drive(0, 10'd7, 1'b0, 1'b0);
    repeat (5) begin
      @(negedge clk);
      chk("R1 level 7 no req", 32'(req0), 0);
    end
    // R3: stray take while idle with empty fifo
    drive(0, 10'd0, 1'b0, 1'b1);
    #1 chk("R3 idle take no pop", 32'(pop0), 0);
    @(negedge clk);
    drive(0, 10'd0, 1'b0, 1'b0);
    chk("R3 idle take no req", 32'(req0), 0);
    chk_addr(0, "R3 idle take addr");

    // randomized bursts on the full-size instance
    for (int k = 0; k < 150; k++)
      run_burst(0, $urandom_range(0, 3), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
    // rest of the odd field, fast
    while (e_field[0] == 0) run_burst(0, 0, 0, 0);
    chk("R6 field toggles", 32'(row0[0]), 1);
    chk("R6 line restarts", 32'(row0[8:1]), 0);
    for (int k = 0; k < 3; k++) run_burst(0, $urandom_range(0, 2), 1, 0);

    // two full frames on the small instance
    for (int k = 0; k < 2 * 20; k++) begin
      run_burst(1, $urandom_range(0, 2), $urandom_range(0, 1), 1'($urandom_range(0, 1)));
      if (e_field[1] == 0 && e_line[1] == 0 && e_col[1] == 0) begin
        chk("R6 frame wrap row", 32'(row1), 0);
        chk("R6 frame wrap col", 32'(col1), 0);
      end
    end
    run_burst(1, 1, 1, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule